// File: doc/BRIEF.md
# I2C Register Slave with Strap-Selected Address

This block is the serial front end of a small register file of eight byte-wide locations. It watches a two-wire I2C bus through separate receive and transmit data pins, so that it can sit behind a pair of opto-isolators. The transmit pin can be built in either polarity. The slave address comes from two three-level strap pins, which arrive already decoded as low, high or open. The block also answers a shared broadcast address, which is accepted for writes only.

A write sends a command byte, and the low three bits of that byte load a register pointer. Each data byte after it is stored at the pointer, and the pointer then advances. A read sets the pointer with a write of the command byte, followed by a repeated Start and the same address with the read bit set. Bytes are then returned from the pointer. The register bank sits outside the block and is reached through one-cycle write and read strobes with a shared address. Bus lines are synchronised to the system clock, and the bus conditions are found from edges on that clock. A synchronous bus-reset input, driven by an external stuck-bus timer, forces the block back to idle.

Top module: `i2c_strap_slave`

## Requirements
- R1: Strap codes are 2'b00 low, 2'b01 high and 2'b10 open; 2'b11 acts as open. The 7-bit own address for each (adr1_i, adr0_i) pair is: (H,L) 1100111, (open,H) 1101000, (H,H) 1101001, (open,open) 1101010, (open,L) 1101011, (L,H) 1101100, (H,open) 1101101, (L,open) 1101110, (L,L) 1101111.
- R2: Address 1100110 with R/W=0 is acknowledged for any strap setting. Address 1100110 with R/W=1 is not acknowledged, and nothing is driven until the next Start or Stop.
- R3: An address byte that matches neither case is not acknowledged. Later bytes are then neither acknowledged nor stored until the next Start.
- R4: The first byte after a write address is a command byte. Bits 2:0 load the pointer, and bits 7:3 have no effect.
- R5: Each data byte that follows the command byte in a write gives a one-cycle reg_wr_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. The pointer then advances by one, and 7 wraps to 0.
- R6: After a repeated Start with the own address and R/W=1, the block returns the byte at the pointer, MSB first. It issues a one-cycle reg_rd_o at that pointer, and the pointer advances after each byte.
- R7: The slave pulls SDA low for the whole ninth clock of every address, command or write-data byte it accepts. It changes SDA only while SCL is low.
- R8: A master NACK on the ninth clock of a read ends output. SDA stays released and no further reg_rd_o is issued until the next Start or Stop.
- R9: A Stop condition returns the block to idle and clears the pointer to 0.
- R10: With page_en_i=0, only one data byte is moved per access. A second write byte is not acknowledged or stored, and a read returns only one byte.
- R11: With INVERT_SDA_O=0, sda_o=0 pulls the line low and sda_o=1 releases it. With INVERT_SDA_O=1, sda_o=1 pulls low and sda_o=0 releases.
- R12: bus_reset_i=1 returns the block to idle, releases SDA and clears the pointer. Bus clocks that follow are ignored until the next Start.
- R13: reg_wr_o and reg_rd_o are never high together, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | Synchronous return to idle from the stuck-bus timer |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, receive side |
| sda_o | output | 1 | Bus data drive, transmit side, polarity set by INVERT_SDA_O |
| adr1_i | input | 2 | Decoded strap 1: 00 low, 01 high, 10 open |
| adr0_i | input | 2 | Decoded strap 0: 00 low, 01 high, 10 open |
| page_en_i | input | 1 | 1 allows multi-byte transfers with auto-increment |
| reg_addr_o | output | 3 | Register pointer presented to the bank |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data from the bank for reg_addr_o, combinational |

## Verification
The assertions assume that SCL and SDA change far more slowly than the system clock. They also assume that a bus master changes SDA only while SCL is low, except when it forms a Start or Stop, so that every edge survives the synchroniser as one clean event. The stimulus drives the bus by bit-banging, with each quarter of an SCL period lasting several system clocks. It moves the data line only in the low phase, except for deliberate Start and Stop conditions. The bench holds the straps steady during a transaction and changes them only between a Stop and the next Start.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'd0,
    STRAP_HIGH = 2'd1,
    STRAP_OPEN = 2'd2
  } strap_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } xfer_state_e;

  // code 2'b11 treated as open
  function automatic strap_e strap_norm(input logic [1:0] code);
    case (code)
      2'd0:    return STRAP_LOW;
      2'd1:    return STRAP_HIGH;
      default: return STRAP_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '1;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edges while clock held high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o))
    else $error("assert_cond_excl_R9");

endmodule

// File: rtl/i2cs_strap_decode.sv
module i2cs_strap_decode
  import i2cs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'b1100110
) (
  input  logic [1:0]        adr1_i,
  input  logic [1:0]        adr0_i,
  output logic [ADDR_W-1:0] own_addr_o
);

  strap_e s1, s0;

  assign s1 = strap_norm(adr1_i);
  assign s0 = strap_norm(adr0_i);

  always_comb begin
    own_addr_o = 7'b1101010;
    case ({s1, s0})
      {STRAP_HIGH, STRAP_LOW }: own_addr_o = 7'b1100111;
      {STRAP_OPEN, STRAP_HIGH}: own_addr_o = 7'b1101000;
      {STRAP_HIGH, STRAP_HIGH}: own_addr_o = 7'b1101001;
      {STRAP_OPEN, STRAP_OPEN}: own_addr_o = 7'b1101010;
      {STRAP_OPEN, STRAP_LOW }: own_addr_o = 7'b1101011;
      {STRAP_LOW,  STRAP_HIGH}: own_addr_o = 7'b1101100;
      {STRAP_HIGH, STRAP_OPEN}: own_addr_o = 7'b1101101;
      {STRAP_LOW,  STRAP_OPEN}: own_addr_o = 7'b1101110;
      {STRAP_LOW,  STRAP_LOW }: own_addr_o = 7'b1101111;
      default:                  own_addr_o = 7'b1101010;
    endcase
  end

  always_comb begin
    assert_addr_not_bcast_R1: assert (own_addr_o != BCAST_ADDR);
  end

endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PTR_W  = 3,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'b1100110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              page_en_i,
  output logic              sda_pull_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  xfer_state_e      state_q;
  logic [CNT_W-1:0] bit_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic [PTR_W-1:0] ptr_q;
  logic             pull_q, is_read_q, m_ack_q, wr_q, rd_q;
  logic [DATA_W-1:0] wdata_q;
  logic             own_hit, bcast_hit, rw_bit;

  assign rw_bit    = rx_q[0];
  assign own_hit   = rx_q[DATA_W-1:1] == own_addr_i;
  assign bcast_hit = (rx_q[DATA_W-1:1] == BCAST_ADDR) && !rw_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      pull_q    <= 1'b0;
      is_read_q <= 1'b0;
      m_ack_q   <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (bus_reset_i || stop_i) begin
        state_q <= ST_IDLE;
        ptr_q   <= '0;
        pull_q  <= 1'b0;
        bit_q   <= '0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        pull_q  <= 1'b0;
        bit_q   <= '0;
      end else begin
        if (wr_q) ptr_q <= ptr_q + PTR_W'(1);
        if (rd_q) begin
          tx_q   <= reg_rdata_i;
          pull_q <= ~reg_rdata_i[DATA_W-1];
          ptr_q  <= ptr_q + PTR_W'(1);
        end
        case (state_q)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise_i && bit_q != FULL) begin
              rx_q  <= {rx_q[DATA_W-2:0], sda_s_i};
              bit_q <= bit_q + CNT_W'(1);
            end else if (scl_fall_i && bit_q == FULL) begin
              bit_q <= '0;
              case (state_q)
                ST_ADDR: begin
                  if (own_hit || bcast_hit) begin
                    is_read_q <= own_hit && rw_bit;
                    pull_q    <= 1'b1;
                    state_q   <= ST_ADDR_ACK;
                  end else begin
                    state_q   <= ST_IGNORE;
                  end
                end
                ST_CMD: begin
                  ptr_q   <= rx_q[PTR_W-1:0];
                  pull_q  <= 1'b1;
                  state_q <= ST_CMD_ACK;
                end
                default: begin
                  wdata_q <= rx_q;
                  wr_q    <= 1'b1;
                  pull_q  <= 1'b1;
                  state_q <= ST_WDATA_ACK;
                end
              endcase
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            pull_q <= 1'b0;
            if (is_read_q) begin
              rd_q    <= 1'b1;
              bit_q   <= CNT_W'(1);
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_CMD;
            end
          end
          ST_CMD_ACK: if (scl_fall_i) begin
            pull_q  <= 1'b0;
            state_q <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall_i) begin
            pull_q  <= 1'b0;
            state_q <= page_en_i ? ST_WDATA : ST_IGNORE;
          end
          ST_RDATA: if (scl_fall_i) begin
            if (bit_q == FULL) begin
              pull_q  <= 1'b0;
              bit_q   <= '0;
              state_q <= ST_RDATA_ACK;
            end else begin
              pull_q <= ~tx_q[DATA_W-2];
              tx_q   <= tx_q << 1;
              bit_q  <= bit_q + CNT_W'(1);
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise_i) m_ack_q <= ~sda_s_i;
            if (scl_fall_i) begin
              if (m_ack_q && page_en_i) begin
                rd_q    <= 1'b1;
                bit_q   <= CNT_W'(1);
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o  = pull_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wr_o    = wr_q;
  assign reg_rd_o    = rd_q;
  assign reg_wdata_o = wdata_q;

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o))
    else $error("assert_strobe_excl_R13");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o)
    else $error("assert_wr_single_R13");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o)
    else $error("assert_rd_single_R13");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && !bus_reset_i && !stop_i) |=> reg_addr_o == $past(reg_addr_o) + PTR_W'(1))
    else $error("assert_ptr_step_R5");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (reg_addr_o == '0 && !sda_pull_o))
    else $error("assert_stop_clears_R9");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (state_q == ST_IDLE && !sda_pull_o && reg_addr_o == '0))
    else $error("assert_bus_reset_R12");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_pull_o) && !$past(bus_reset_i) && !$past(stop_i)) |-> !scl_s_i)
    else $error("assert_sda_low_phase_R7");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !sda_pull_o)
    else $error("assert_ignore_released_R8");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDATA_ACK && scl_fall_i && !page_en_i && !bus_reset_i && !stop_i && !start_i)
      |=> state_q == ST_IGNORE)
    else $error("assert_single_byte_R10");

endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave #(
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PTR_W        = 3,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          INVERT_SDA_O = 1'b0,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'b1100110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  input  logic [1:0]        adr1_i,
  input  logic [1:0]        adr0_i,
  input  logic              page_en_i,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);

  logic [1:0]        bus_s;
  logic              scl_rise, scl_fall, start_det, stop_det, sda_pull;
  logic [ADDR_W-1:0] own_addr;

  i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (bus_s)
  );

  i2cs_cond_detect i_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (bus_s[1]),
    .sda_s_i    (bus_s[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2cs_strap_decode #(.ADDR_W(ADDR_W), .BCAST_ADDR(BCAST_ADDR)) i_strap (
    .adr1_i     (adr1_i),
    .adr0_i     (adr0_i),
    .own_addr_o (own_addr)
  );

  i2cs_xfer_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .BCAST_ADDR(BCAST_ADDR)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .scl_s_i     (bus_s[1]),
    .sda_s_i     (bus_s[0]),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .own_addr_i  (own_addr),
    .page_en_i   (page_en_i),
    .sda_pull_o  (sda_pull),
    .reg_addr_o  (reg_addr_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rd_o    (reg_rd_o),
    .reg_rdata_i (reg_rdata_i)
  );

  if (INVERT_SDA_O) begin : g_inv
    assign sda_o = sda_pull;
  end else begin : g_direct
    assign sda_o = ~sda_pull;
  end

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull |-> (sda_o == INVERT_SDA_O))
    else $error("assert_polarity_R11");

endmodule

// File: tb/test_i2c_strap_slave.sv
`timescale 1ns/1ps
module test_i2c_strap_slave;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] adr1 = 2'd1, adr0 = 2'd0;
  logic       page_en = 1'b1;

  logic       sda_o, sda_o_inv;
  logic [2:0] reg_addr, reg_addr_inv;
  logic       reg_wr, reg_rd, reg_wr_inv, reg_rd_inv;
  logic [7:0] reg_wdata, reg_wdata_inv, reg_rdata;
  logic [7:0] bank [8];
  logic [7:0] exp_bank [8];
  wire        sda_line = m_sda & sda_o & ~sda_o_inv;

  int n_checks = 0, n_fail = 0, n_wr = 0, n_rd = 0, n_both = 0;
  logic ack, ack_inv_o, ack_main_o;
  logic [7:0] rbyte;
  logic [2:0] wr_seq [4];

  always #2 clk = ~clk;

  i2c_strap_slave i_i2c_strap_slave (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset),
    .scl_i(scl), .sda_i(sda_line), .sda_o(sda_o),
    .adr1_i(adr1), .adr0_i(adr0), .page_en_i(page_en),
    .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  i2c_strap_slave #(.INVERT_SDA_O(1'b1)) i_i2c_strap_slave_inv (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset),
    .scl_i(scl), .sda_i(sda_line), .sda_o(sda_o_inv),
    .adr1_i(2'd0), .adr0_i(2'd0), .page_en_i(page_en),
    .reg_addr_o(reg_addr_inv), .reg_wr_o(reg_wr_inv), .reg_wdata_o(reg_wdata_inv),
    .reg_rd_o(reg_rd_inv), .reg_rdata_i(8'h3C)
  );

  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bank[i] <= 8'hA0 + 8'(i);
    end else if (reg_wr) begin
      bank[reg_addr] <= reg_wdata;
    end
    if (rst_n && reg_wr) begin
      if (n_wr < 4) wr_seq[n_wr] <= reg_addr;
      n_wr <= n_wr + 1;
    end
    if (rst_n && reg_rd) n_rd <= n_rd + 1;
    if (rst_n && reg_wr && reg_rd) n_both <= n_both + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    a = ~sda_line; ack_inv_o = sda_o_inv; ack_main_o = sda_o;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
    end
    m_sda = ~give_ack; wq(); scl = 1'b1; wq(2); scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a7, input logic [7:0] cmd, input logic [7:0] d,
                        input string req);
    logic a;
    bus_start();
    send_byte({a7, 1'b0}, a); check(a, req, a, 1);
    send_byte(cmd, a);        check(a, req, a, 1);
    send_byte(d, a);          check(a, req, a, 1);
    bus_stop();
    exp_bank[cmd[2:0]] = d;
  endtask

  task automatic rd_one(input logic [6:0] a7, input logic [7:0] cmd, output logic [7:0] b);
    logic a;
    bus_start();
    send_byte({a7, 1'b0}, a);
    send_byte(cmd, a);
    bus_start();
    send_byte({a7, 1'b1}, a);
    recv_byte(1'b0, b);
    bus_stop();
  endtask

  // {adr1, adr0, address}
  localparam logic [10:0] STRAP_VEC [9] = '{
    {2'd1, 2'd0, 7'b1100111}, {2'd2, 2'd1, 7'b1101000}, {2'd1, 2'd1, 7'b1101001},
    {2'd2, 2'd2, 7'b1101010}, {2'd2, 2'd0, 7'b1101011}, {2'd0, 2'd1, 7'b1101100},
    {2'd1, 2'd2, 7'b1101101}, {2'd0, 2'd2, 7'b1101110}, {2'd0, 2'd0, 7'b1101111}
  };

  // {command, data}
  localparam logic [15:0] WR_VEC [6] = '{
    16'h0211, 16'hF922, 16'h0733, 16'h8044, 16'h2C55, 16'h1366
  };

  localparam logic [6:0] OWN = 7'b1100111;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic a;
    int wr0, rd0;
    for (int i = 0; i < 8; i++) exp_bank[i] = 8'hA0 + 8'(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state, R11 released levels
    check(sda_o == 1'b1, "R11", sda_o, 1);
    check(sda_o_inv == 1'b0, "R11", sda_o_inv, 0);
    check(!reg_wr && !reg_rd, "R13", {reg_wr, reg_rd}, 0);
    check(reg_addr == 3'd0, "R9", reg_addr, 0);

    // R1 strap table
    foreach (STRAP_VEC[k]) begin
      adr1 = STRAP_VEC[k][10:9]; adr0 = STRAP_VEC[k][8:7];
      wq(2);
      bus_start();
      send_byte({STRAP_VEC[k][6:0], 1'b0}, a);
      check(a, "R1", a, 1);
      bus_stop();
    end
    adr1 = 2'd3; adr0 = 2'd3; wq(2);
    bus_start(); send_byte({7'b1101010, 1'b0}, a); check(a, "R1", a, 1); bus_stop();
    adr1 = 2'd1; adr0 = 2'd0; wq(2);

    // R4, R6, R7 write/read pairs
    foreach (WR_VEC[k]) begin
      wr_txn(OWN, WR_VEC[k][15:8], WR_VEC[k][7:0], "R7");
      rd_one(OWN, WR_VEC[k][15:8], rbyte);
      check(rbyte == exp_bank[WR_VEC[k][10:8]], "R4", rbyte, exp_bank[WR_VEC[k][10:8]]);
    end

    // R5 auto-increment with wrap, R6 multi-byte read
    wr0 = n_wr;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h06, a);
    send_byte(8'hA1, a); check(a, "R5", a, 1);
    send_byte(8'hB2, a); check(a, "R5", a, 1);
    send_byte(8'hC3, a); check(a, "R5", a, 1);
    bus_stop();
    check(n_wr - wr0 == 3, "R5", n_wr - wr0, 3);
    check(wr_seq[0] == 3'd6 || wr0 != 0, "R5", wr_seq[0], 6);
    exp_bank[6] = 8'hA1; exp_bank[7] = 8'hB2; exp_bank[0] = 8'hC3;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h06, a);
    bus_start();
    send_byte({OWN, 1'b1}, a); check(a, "R6", a, 1);
    recv_byte(1'b1, rbyte); check(rbyte == 8'hA1, "R6", rbyte, 8'hA1);
    recv_byte(1'b1, rbyte); check(rbyte == 8'hB2, "R6", rbyte, 8'hB2);
    recv_byte(1'b0, rbyte); check(rbyte == 8'hC3, "R5", rbyte, 8'hC3);
    // R8 after NACK nothing is driven
    rd0 = n_rd;
    recv_byte(1'b1, rbyte); check(rbyte == 8'hFF, "R8", rbyte, 8'hFF);
    check(n_rd == rd0, "R8", n_rd, rd0);
    bus_stop();

    // R10 single byte per access
    page_en = 1'b0;
    wr0 = n_wr;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h02, a);
    send_byte(8'h77, a); check(a, "R10", a, 1);
    send_byte(8'h88, a); check(!a, "R10", a, 0);
    bus_stop();
    exp_bank[2] = 8'h77;
    check(n_wr - wr0 == 1, "R10", n_wr - wr0, 1);
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte({OWN, 1'b1}, a);
    recv_byte(1'b1, rbyte); check(rbyte == 8'h77, "R10", rbyte, 8'h77);
    recv_byte(1'b1, rbyte); check(rbyte == 8'hFF, "R10", rbyte, 8'hFF);
    bus_stop();
    page_en = 1'b1;
    rd_one(OWN, 8'h03, rbyte); check(rbyte == exp_bank[3], "R10", rbyte, exp_bank[3]);

    // R2 broadcast
    wr_txn(7'b1100110, 8'h04, 8'h9D, "R2");
    rd_one(OWN, 8'h04, rbyte); check(rbyte == 8'h9D, "R2", rbyte, 8'h9D);
    bus_start();
    send_byte({7'b1100110, 1'b1}, a); check(!a, "R2", a, 0);
    recv_byte(1'b1, rbyte); check(rbyte == 8'hFF, "R2", rbyte, 8'hFF);
    bus_stop();

    // R3 foreign address
    wr0 = n_wr;
    bus_start();
    send_byte(8'hA0, a); check(!a, "R3", a, 0);
    send_byte(8'h01, a); check(!a, "R3", a, 0);
    send_byte(8'h5E, a); check(!a, "R3", a, 0);
    bus_stop();
    check(n_wr == wr0, "R3", n_wr, wr0);

    // R9 stop clears pointer
    wr_txn(OWN, 8'h05, 8'h5A, "R9");
    bus_start();
    send_byte({OWN, 1'b1}, a);
    recv_byte(1'b0, rbyte); check(rbyte == exp_bank[0], "R9", rbyte, exp_bank[0]);
    bus_stop();

    // R12 bus reset mid-transfer
    wr0 = n_wr;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h03, a);
    @(negedge clk); bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    repeat (2) @(negedge clk);
    check(reg_addr == 3'd0, "R12", reg_addr, 0);
    send_byte(8'hE7, a); check(!a, "R12", a, 0);
    bus_stop();
    check(n_wr == wr0, "R12", n_wr, wr0);

    // R11 inverted output drives high to pull low
    bus_start();
    send_byte({7'b1101111, 1'b0}, a);
    check(a, "R11", a, 1);
    check(ack_inv_o == 1'b1, "R11", ack_inv_o, 1);
    check(ack_main_o == 1'b1, "R11", ack_main_o, 1);
    bus_stop();

    check(n_both == 0, "R13", n_both, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule